// File: doc/BRIEF.md
# Register-File ALU with In-File Flag Register

This block pairs an 8-bit arithmetic and logic unit with a sixteen-entry register file. The highest register doubles as the flag register, so the flag is both an ordinary operand and a side result. A caller pulses `start` for one cycle with an operation kind, a 4-bit operation code, a destination/first-operand index X, a second-operand index Y and an 8-bit constant. The unit reads both registers, computes the result, writes it to register X, updates the flag where the operation calls for it, and pulses `done` on the next cycle.

Register-register operations cover copy, OR, AND, XOR, add with carry, two subtract directions with an inverted-borrow flag, and one-bit shifts in either direction that capture the bit shifted out. Two constant operations, load and wrapping add, leave the flag alone. When X names the flag register, a fixed order of the two writes decides which value survives. Any code outside the defined set changes nothing and raises an illegal-operation pulse. A combinational read port exposes any register.

Top module: `regalu_core`

## Requirements
- R1: After reset every register reads zero and `done` and `illegal` are low.
- R2: With kind 0 (register operations), code 0 copies register Y into X, and codes 1, 2 and 3 write X OR Y, X AND Y and X XOR Y into X; the flag register is unchanged unless it is X.
- R3: Kind 0, code 4 writes the low 8 bits of X+Y into X and sets the flag register to 1 when the 9-bit sum exceeds 255, otherwise to 0.
- R4: Kind 0, code 5 writes X−Y and code 7 writes Y−X (both modulo 256) into X; the flag register becomes 1 when the subtraction needs no borrow (minuend ≥ subtrahend) and 0 otherwise.
- R5: Kind 0, code 6 writes X shifted right by one into X, ignoring Y, and the flag register receives old bit 0 of X.
- R6: Kind 0, code 14 writes X shifted left by one (modulo 256) into X and the flag register receives old bit 7 of X.
- R7: For codes 4, 5 and 7 with X equal to 15, register 15 ends holding the arithmetic result, not the flag.
- R8: For codes 6 and 14 with X equal to 15, register 15 ends holding the shifted-out bit, not the shift result.
- R9: Kind 1 loads the constant into X; kind 2 adds the constant to X modulo 256; neither changes the flag register unless it is X.
- R10: Kind 0 with a code outside {0..7, 14}, or kind 3, changes no register and raises `illegal` for the one cycle in which `done` is high.
- R11: `done` is high exactly in the cycle after each cycle in which `start` is sampled high, and the written values are visible on the read port in that cycle; back-to-back strobes are accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation strobe, sampled each rising edge |
| kind | input | 2 | 0 register op, 1 load constant, 2 add constant, 3 reserved |
| opcode | input | 4 | Register operation code (kind 0 only) |
| x_idx | input | 4 | Destination and first operand register |
| y_idx | input | 4 | Second operand register |
| imm | input | 8 | Constant for kinds 1 and 2 |
| rd_idx | input | 4 | Read port register index |
| rd_data | output | 8 | Current value of register `rd_idx` |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Undefined-operation pulse |

## Verification
The assertions assume that `kind`, `opcode`, `x_idx` and `y_idx` are valid whenever `start` is high and that the strobe is a single sampled level per operation, so a held strobe counts as consecutive operations. The stimulus changes inputs only on falling edges, holds them through the sampling edge, and reaches flag-register-as-destination, equal operands, carry and borrow boundaries and every undefined code before a long seeded mix of all kinds and indices.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

    typedef enum logic [1:0] {
        K_REG  = 2'b00,
        K_LDI  = 2'b01,
        K_ADDI = 2'b10,
        K_RSV  = 2'b11
    } kind_e;

    typedef enum logic [3:0] {
        F_MOV,
        F_OR,
        F_AND,
        F_XOR,
        F_ADD,
        F_SUB,
        F_SHR,
        F_RSUB,
        F_SHL,
        F_LDI,
        F_ADDI,
        F_NOP
    } fn_e;

    localparam logic [3:0] OP_MOV  = 4'h0;
    localparam logic [3:0] OP_OR   = 4'h1;
    localparam logic [3:0] OP_AND  = 4'h2;
    localparam logic [3:0] OP_XOR  = 4'h3;
    localparam logic [3:0] OP_ADD  = 4'h4;
    localparam logic [3:0] OP_SUB  = 4'h5;
    localparam logic [3:0] OP_SHR  = 4'h6;
    localparam logic [3:0] OP_RSUB = 4'h7;
    localparam logic [3:0] OP_SHL  = 4'hE;

endpackage

// File: rtl/regalu_decode.sv
module regalu_decode
    import regalu_pkg::*;
(
    input  kind_e      kind,
    input  logic [3:0] opcode,
    output fn_e        fn,
    output logic       bad_op
);

    always_comb begin
        fn     = F_NOP;
        bad_op = 1'b0;
        unique case (kind)
            K_REG: begin
                unique case (opcode)
                    OP_MOV:  fn = F_MOV;
                    OP_OR:   fn = F_OR;
                    OP_AND:  fn = F_AND;
                    OP_XOR:  fn = F_XOR;
                    OP_ADD:  fn = F_ADD;
                    OP_SUB:  fn = F_SUB;
                    OP_SHR:  fn = F_SHR;
                    OP_RSUB: fn = F_RSUB;
                    OP_SHL:  fn = F_SHL;
                    default: bad_op = 1'b1;
                endcase
            end
            K_LDI:   fn = F_LDI;
            K_ADDI:  fn = F_ADDI;
            default: bad_op = 1'b1;
        endcase
    end

endmodule

// File: rtl/regalu_exec.sv
module regalu_exec
    import regalu_pkg::*;
#(
    parameter int DW = 8
) (
    input  fn_e           fn,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [DW-1:0] imm,
    output logic [DW-1:0] res,
    output logic          res_we,
    output logic [DW-1:0] flg,
    output logic          flg_we,
    output logic          flag_last
);

    localparam int WW = DW + 1;

    logic [WW-1:0] wide;
    logic          fbit;

    always_comb begin
        res       = '0;
        res_we    = 1'b1;
        fbit      = 1'b0;
        flg_we    = 1'b0;
        flag_last = 1'b0;
        wide      = '0;
        unique case (fn)
            F_MOV: res = opb;
            F_OR:  res = opa | opb;
            F_AND: res = opa & opb;
            F_XOR: res = opa ^ opb;
            F_ADD: begin
                wide   = {1'b0, opa} + {1'b0, opb};
                res    = wide[DW-1:0];
                fbit   = wide[DW];
                flg_we = 1'b1;
            end
            F_SUB: begin
                wide   = {1'b0, opa} - {1'b0, opb};
                res    = wide[DW-1:0];
                fbit   = ~wide[DW];
                flg_we = 1'b1;
            end
            F_RSUB: begin
                wide   = {1'b0, opb} - {1'b0, opa};
                res    = wide[DW-1:0];
                fbit   = ~wide[DW];
                flg_we = 1'b1;
            end
            F_SHR: begin
                res       = opa >> 1;
                fbit      = opa[0];
                flg_we    = 1'b1;
                flag_last = 1'b1;
            end
            F_SHL: begin
                res       = opa << 1;
                fbit      = opa[DW-1];
                flg_we    = 1'b1;
                flag_last = 1'b1;
            end
            F_LDI:  res = imm;
            F_ADDI: res = opa + imm;
            default: res_we = 1'b0;
        endcase
        flg = {{(DW-1){1'b0}}, fbit};
    end

endmodule

// File: rtl/regalu_wb.sv
module regalu_wb #(
    parameter int DW   = 8,
    parameter int NREG = 16,
    parameter int AW   = $clog2(NREG)
) (
    input  logic [NREG-1:0][DW-1:0] regs_cur,
    input  logic [AW-1:0]           dst,
    input  logic                    res_we,
    input  logic [DW-1:0]           res,
    input  logic                    flg_we,
    input  logic [DW-1:0]           flg,
    input  logic                    flag_last,
    output logic [NREG-1:0][DW-1:0] regs_nxt
);

    localparam int FLAG = NREG - 1;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic hit;
        assign hit = res_we && (dst == AW'(i));
        if (i == FLAG) begin : g_flag
            always_comb begin
                regs_nxt[i] = regs_cur[i];
                if (flag_last) begin
                    if (hit)    regs_nxt[i] = res;
                    if (flg_we) regs_nxt[i] = flg;
                end else begin
                    if (flg_we) regs_nxt[i] = flg;
                    if (hit)    regs_nxt[i] = res;
                end
            end
        end else begin : g_gpr
            always_comb begin
                regs_nxt[i] = hit ? res : regs_cur[i];
            end
        end
    end

endmodule

// File: rtl/regalu_core.sv
module regalu_core
    import regalu_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    kind,
    input  logic [3:0]    opcode,
    input  logic [3:0]    x_idx,
    input  logic [3:0]    y_idx,
    input  logic [DW-1:0] imm,
    input  logic [3:0]    rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic          illegal
);

    localparam int AW = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic                    done;
        logic                    illegal;
    } state_t;

    state_t st_d, st_q;

    fn_e           fn;
    logic          bad_op;
    logic [DW-1:0] ex_res, ex_flg;
    logic          ex_res_we, ex_flg_we, ex_flag_last;
    logic [NREG-1:0][DW-1:0] regs_view, regs_wb;
    logic [AW-1:0] xa, ya, ra;

    assign regs_view = st_q.regs;
    assign xa        = AW'(x_idx);
    assign ya        = AW'(y_idx);
    assign ra        = AW'(rd_idx);

    regalu_decode u_dec (
        .kind   (kind_e'(kind)),
        .opcode (opcode),
        .fn     (fn),
        .bad_op (bad_op)
    );

    regalu_exec #(.DW(DW)) u_exe (
        .fn        (fn),
        .opa       (regs_view[xa]),
        .opb       (regs_view[ya]),
        .imm       (imm),
        .res       (ex_res),
        .res_we    (ex_res_we),
        .flg       (ex_flg),
        .flg_we    (ex_flg_we),
        .flag_last (ex_flag_last)
    );

    regalu_wb #(.DW(DW), .NREG(NREG), .AW(AW)) u_wb (
        .regs_cur  (regs_view),
        .dst       (xa),
        .res_we    (ex_res_we),
        .res       (ex_res),
        .flg_we    (ex_flg_we),
        .flg       (ex_flg),
        .flag_last (ex_flag_last),
        .regs_nxt  (regs_wb)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = start;
        st_d.illegal = start && bad_op;
        if (start && !bad_op) st_d.regs = regs_wb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = regs_view[ra];
    assign done    = st_q.done;
    assign illegal = st_q.illegal;

endmodule

// File: rtl/regalu_chk.sv
module regalu_chk #(
    parameter int DW   = 8,
    parameter int NREG = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [1:0]              kind,
    input logic [3:0]              opcode,
    input logic [3:0]              x_idx,
    input logic [3:0]              y_idx,
    input logic                    done,
    input logic                    illegal,
    input logic [NREG-1:0][DW-1:0] regs
);

    localparam int          AW   = $clog2(NREG);
    localparam logic [3:0]  FLAG = 4'(NREG - 1);

    logic [DW:0] add_now;
    assign add_now = {1'b0, regs[AW'(x_idx)]} + {1'b0, regs[AW'(y_idx)]};

    a_r11_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r11_no_done_without_start: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    a_r10_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);

    a_r10_illegal_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> regs == $past(regs));

    a_r9_addi_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (start && kind == 2'b10 && x_idx != FLAG) |=> regs[NREG-1] == $past(regs[NREG-1]));

    a_r3_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (start && kind == 2'b00 && opcode == 4'h4 && x_idx != FLAG)
        |=> regs[NREG-1] == {{(DW-1){1'b0}}, $past(add_now[DW])});

    a_r8_shr_flag_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (start && kind == 2'b00 && opcode == 4'h6 && x_idx == FLAG)
        |=> regs[NREG-1] == {{(DW-1){1'b0}}, $past(regs[NREG-1][0])});

endmodule

bind regalu_core regalu_chk #(.DW(DW), .NREG(NREG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .kind    (kind),
    .opcode  (opcode),
    .x_idx   (x_idx),
    .y_idx   (y_idx),
    .done    (done),
    .illegal (illegal),
    .regs    (regs_view)
);

// File: tb/regalu_core_test.sv
`timescale 1ns/1ps
module regalu_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] kind = '0;
    logic [3:0] opcode = '0, x_idx = '0, y_idx = '0, rd_idx = '0;
    logic [7:0] imm = '0;
    logic [7:0] rd_data;
    logic       done, illegal;

    int n_cmp = 0;
    int n_bad = 0;
    int mdl [16];

    always #10 clk = ~clk;

    regalu_core uut (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .opcode(opcode),
        .x_idx(x_idx), .y_idx(y_idx), .imm(imm), .rd_idx(rd_idx),
        .rd_data(rd_data), .done(done), .illegal(illegal)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic sweep(input string tag);
        for (int r = 0; r < 16; r++) begin
            rd_idx = 4'(r);
            #1;
            chk($sformatf("%s reg%0d", tag, r), int'(rd_data), mdl[r]);
        end
    endtask

    // Behavioural model step; returns whether the operation is undefined
    function automatic bit model(input int k, input int o, input int x, input int y, input int c);
        int a = mdl[x];
        int b = mdl[y];
        bit ill = 0;
        if (k == 0) begin
            case (o)
                0:  mdl[x] = b;
                1:  mdl[x] = a | b;
                2:  mdl[x] = a & b;
                3:  mdl[x] = a ^ b;
                4:  begin mdl[15] = (a + b > 255); mdl[x] = (a + b) % 256; end
                5:  begin mdl[15] = (a >= b); mdl[x] = (a - b + 256) % 256; end
                7:  begin mdl[15] = (b >= a); mdl[x] = (b - a + 256) % 256; end
                6:  begin mdl[x] = a / 2; mdl[15] = a % 2; end
                14: begin mdl[x] = (a * 2) % 256; mdl[15] = a / 128; end
                default: ill = 1;
            endcase
        end else if (k == 1) mdl[x] = c;
        else if (k == 2) mdl[x] = (a + c) % 256;
        else ill = 1;
        return ill;
    endfunction

    task automatic run(input string tag, input int k, input int o, input int x, input int y, input int c);
        bit ill;
        @(negedge clk);
        start = 1'b1; kind = 2'(k); opcode = 4'(o); x_idx = 4'(x); y_idx = 4'(y); imm = 8'(c);
        @(negedge clk);
        start = 1'b0;
        ill = model(k, o, x, y, c);
        chk({tag, " done"}, int'(done), 1);
        chk({tag, " illegal"}, int'(illegal), int'(ill));
        sweep(tag);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        for (int r = 0; r < 16; r++) mdl[r] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", int'(done), 0);
        chk("R1 illegal", int'(illegal), 0);
        sweep("R1");

        run("R9 ldi", 1, 0, 1, 0, 8'hC3);
        run("R9 ldi", 1, 0, 2, 0, 8'h5A);
        run("R2 mov", 0, 0, 3, 1, 0);
        run("R2 or",  0, 1, 3, 2, 0);
        run("R2 and", 0, 2, 1, 2, 0);
        run("R2 xor", 0, 3, 2, 3, 0);
        run("R9 ldi", 1, 0, 4, 0, 200);
        run("R9 ldi", 1, 0, 5, 0, 56);
        run("R3 add exact 256", 0, 4, 4, 5, 0);
        run("R9 ldi", 1, 0, 4, 0, 199);
        run("R3 add 255", 0, 4, 4, 5, 0);
        run("R9 ldi", 1, 0, 6, 0, 30);
        run("R9 ldi", 1, 0, 7, 0, 30);
        run("R4 sub equal", 0, 5, 6, 7, 0);
        run("R4 sub borrow", 0, 5, 6, 7, 0);
        run("R4 rsub", 0, 7, 6, 7, 0);
        run("R9 ldi", 1, 0, 8, 0, 8'h81);
        run("R5 shr", 0, 6, 8, 3, 0);
        run("R6 shl", 0, 14, 8, 9, 0);
        run("R9 ldi", 1, 0, 8, 0, 8'hC0);
        run("R6 shl msb", 0, 14, 8, 8, 0);
        run("R9 ldi", 1, 0, 15, 0, 250);
        run("R7 add x15", 0, 4, 15, 1, 0);
        run("R9 ldi", 1, 0, 15, 0, 3);
        run("R7 sub x15", 0, 5, 15, 6, 0);
        run("R7 rsub x15", 0, 7, 15, 2, 0);
        run("R9 ldi", 1, 0, 15, 0, 8'hFE);
        run("R8 shl x15", 0, 14, 15, 0, 0);
        run("R9 ldi", 1, 0, 15, 0, 8'h03);
        run("R8 shr x15", 0, 6, 15, 0, 0);
        run("R9 ldi", 1, 0, 15, 0, 8'h55);
        run("R9 addi wrap", 2, 0, 1, 0, 8'hF0);
        run("R2 or keeps flag", 0, 1, 9, 1, 0);
        for (int o = 8; o < 16; o++)
            if (o != 14) run("R10 undefined code", 0, o, 2, 1, 0);
        run("R10 reserved kind", 3, 4, 2, 1, 8'h11);

        // R11: back-to-back strobes and idle cycle
        @(negedge clk);
        start = 1'b1; kind = 2'd1; x_idx = 4'd10; imm = 8'd77;
        @(negedge clk);
        void'(model(1, 0, 10, 0, 77));
        kind = 2'd2; x_idx = 4'd10; imm = 8'd100;
        chk("R11 first done", int'(done), 1);
        rd_idx = 4'd10; #1;
        chk("R11 first value", int'(rd_data), mdl[10]);
        @(negedge clk);
        start = 1'b0;
        void'(model(2, 0, 10, 0, 100));
        chk("R11 second done", int'(done), 1);
        rd_idx = 4'd10; #1;
        chk("R11 second value", int'(rd_data), mdl[10]);
        @(negedge clk);
        chk("R11 idle done", int'(done), 0);

        for (int t = 0; t < 400; t++) begin
            int k = $urandom_range(0, 3);
            int o = $urandom_range(0, 15);
            int x = $urandom_range(0, 15);
            int y = $urandom_range(0, 15);
            int c = $urandom_range(0, 255);
            if (k == 3 && t % 4 != 0) k = 0;
            run("mix R2 R3 R4 R5 R6 R7 R8 R9 R10", k, o, x, y, c);
        end

        summary();
        $finish;
    end

endmodule